// File: doc/BRIEF.md
# Conditional Sum Adder

This block adds two unsigned operands and a carry-in without rippling a carry from bit to bit. Every bit position first works out two speculative answers, one for an incoming carry of zero and one for an incoming carry of one. A tree of two-way selectors then joins neighbouring groups in pairs. Within each pair, the lower group's two speculative carries pick the upper group's speculative sums and carry. After log2(WIDTH) joining levels, one group covers the whole word, and the real carry-in picks between its two finished answers.

The adder core is purely combinational. In keeping with the surrounding code base, the result is captured in one output register with a synchronous, active-high reset. A new operand set can therefore be applied every cycle, and its result appears one clock edge later. The width is a parameter. It must be a power of two, and elaboration stops with an error for any other value.

Top module: `csa_adder_top`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `sum` and `cout` are zero after that edge.
- R2: When `rst` is low at a rising edge, after that edge `{cout, sum}` equals the (WIDTH+1)-bit value of `a + b + cin`, taken from the inputs at that edge.
- R3: At the default width of 4, R2 holds for every one of the 512 combinations of `a`, `b` and `cin`.
- R4: When every bit position propagates (`b` equals the bitwise inverse of `a`), the result has these values:
  - with `cin` = 0, `sum` is all ones and `cout` is 0;
  - with `cin` = 1, `sum` is zero and `cout` is 1.
- R5: When `a` and `b` are both zero, `sum` equals `cin` (bit 0 set only if `cin` is 1) and `cout` is 0.
- R6: When the most significant bits of `a` and `b` are both 1, `cout` is 1 on the next cycle.
- R7: When `rst` is high in the same cycle as nonzero operands, the operands are discarded and the outputs are zero. The cycle after `rst` falls, those same held operands give the correct sum.
- R8: At a width of 16, R2 holds for both random and directed operands, including full-word propagate chains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the output register captures on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a | input | WIDTH | First addend |
| b | input | WIDTH | Second addend |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Registered sum |
| cout | output | 1 | Registered carry out of the top bit |

## Verification
Two of the block's functions can fall in the same cycle: the synchronous reset and the capture of a fresh result. The bench provokes this by raising `rst` at the very edge where all-ones operands and a set carry-in are presented. It expects all-zero outputs, and then, one edge after `rst` drops with the operands unchanged, the full sum with a carry out. The same edge-by-edge reasoning applies to the carry path. A full propagate chain makes `cin` alone decide every output bit. The bench drives that pattern at both widths, with `cin` flipped between consecutive vectors, so the final selector must change the whole word from one edge to the next.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // Four speculative outputs of one bit position
  typedef struct packed {
    logic sum0;
    logic cry0;
    logic sum1;
    logic cry1;
  } csa_cand_t;

  function automatic bit csa_is_pow2(input int unsigned w);
    return (w != 0) && ((w & (w - 1)) == 0);
  endfunction

  // Start of level k's carry slice inside the flat carry vectors.
  // Level k holds w >> k group carries.
  function automatic int unsigned csa_carry_off(input int unsigned w,
                                                input int unsigned k);
    return 2 * w - 2 * (w >> k);
  endfunction

endpackage

// File: rtl/csa_cell.sv
module csa_cell
  import csa_pkg::*;
(
  input  logic      a_i,
  input  logic      b_i,
  output csa_cand_t cand_o
);

  logic half_w;

  always_comb begin
    half_w       = a_i ^ b_i;
    cand_o.sum0  = half_w;
    cand_o.cry0  = a_i & b_i;
    cand_o.sum1  = ~half_w;
    cand_o.cry1  = a_i | b_i;
  end

endmodule

// File: rtl/csa_merge.sv
// One joining level: NG groups of GS bits each become NG/2 groups of 2*GS bits
module csa_merge #(
  parameter int GS = 1,
  parameter int NG = 2
) (
  input  logic [NG*GS-1:0] s0_i,
  input  logic [NG*GS-1:0] s1_i,
  input  logic [NG-1:0]    c0_i,
  input  logic [NG-1:0]    c1_i,
  output logic [NG*GS-1:0] s0_o,
  output logic [NG*GS-1:0] s1_o,
  output logic [NG/2-1:0]  c0_o,
  output logic [NG/2-1:0]  c1_o
);

  localparam int NO = NG / 2;

  for (genvar p = 0; p < NO; p++) begin : g_pair
    localparam int LO = 2 * p * GS;
    localparam int HI = (2 * p + 1) * GS;

    // lower half passes through unchanged under either assumption
    assign s0_o[LO +: GS] = s0_i[LO +: GS];
    assign s1_o[LO +: GS] = s1_i[LO +: GS];

    // lower group's carry for each assumption steers the upper group
    assign s0_o[HI +: GS] = c0_i[2*p] ? s1_i[HI +: GS] : s0_i[HI +: GS];
    assign s1_o[HI +: GS] = c1_i[2*p] ? s1_i[HI +: GS] : s0_i[HI +: GS];
    assign c0_o[p]        = c0_i[2*p] ? c1_i[2*p+1]    : c0_i[2*p+1];
    assign c1_o[p]        = c1_i[2*p] ? c1_i[2*p+1]    : c0_i[2*p+1];
  end

endmodule

// File: rtl/csa_select.sv
module csa_select #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] s0_i,
  input  logic [WIDTH-1:0] s1_i,
  input  logic             c0_i,
  input  logic             c1_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  always_comb begin
    sum_o  = cin_i ? s1_i : s0_i;
    cout_o = cin_i ? c1_i : c0_i;
  end

endmodule

// File: rtl/csa_adder_top.sv
module csa_adder_top
  import csa_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int LEVELS = $clog2(WIDTH);
  localparam int CBITS  = 2 * WIDTH - 1;
  localparam int CTOP   = csa_carry_off(WIDTH, LEVELS);

  if (!csa_is_pow2(WIDTH)) begin : g_bad_width
    $error("csa_adder_top: WIDTH must be a power of two");
  end

  csa_cand_t        cand [WIDTH];
  logic [WIDTH-1:0] lvl_s0 [LEVELS+1];
  logic [WIDTH-1:0] lvl_s1 [LEVELS+1];
  logic [CBITS-1:0] lvl_c0;
  logic [CBITS-1:0] lvl_c1;
  logic [WIDTH-1:0] sel_sum;
  logic             sel_cout;

  // bit cells feed level 0
  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    csa_cell u_cell (
      .a_i    (a[i]),
      .b_i    (b[i]),
      .cand_o (cand[i])
    );
    assign lvl_s0[0][i] = cand[i].sum0;
    assign lvl_s1[0][i] = cand[i].sum1;
    assign lvl_c0[i]    = cand[i].cry0;
    assign lvl_c1[i]    = cand[i].cry1;
  end

  // joining tree
  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    localparam int NG_K   = WIDTH >> k;
    localparam int OFF_IN = csa_carry_off(WIDTH, k);
    localparam int OFF_OT = csa_carry_off(WIDTH, k + 1);

    csa_merge #(
      .GS (1 << k),
      .NG (NG_K)
    ) u_merge (
      .s0_i (lvl_s0[k]),
      .s1_i (lvl_s1[k]),
      .c0_i (lvl_c0[OFF_IN +: NG_K]),
      .c1_i (lvl_c1[OFF_IN +: NG_K]),
      .s0_o (lvl_s0[k+1]),
      .s1_o (lvl_s1[k+1]),
      .c0_o (lvl_c0[OFF_OT +: NG_K/2]),
      .c1_o (lvl_c1[OFF_OT +: NG_K/2])
    );
  end

  csa_select #(
    .WIDTH (WIDTH)
  ) u_select (
    .s0_i   (lvl_s0[LEVELS]),
    .s1_i   (lvl_s1[LEVELS]),
    .c0_i   (lvl_c0[CTOP]),
    .c1_i   (lvl_c1[CTOP]),
    .cin_i  (cin),
    .sum_o  (sel_sum),
    .cout_o (sel_cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum  <= '0;
      cout <= 1'b0;
    end else begin
      sum  <= sel_sum;
      cout <= sel_cout;
    end
  end

endmodule

// File: rtl/csa_adder_chk.sv
module csa_adder_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout
);

  logic [WIDTH:0] ref_w;
  assign ref_w = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (sum == '0 && !cout)); // R1

  AST_RESET_WINS: assert property (@(posedge clk)
    (rst && (a != '0 || b != '0 || cin)) |=> (sum == '0)); // R7

  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ({cout, sum} == $past(ref_w))); // R2

  AST_FULL_PROPAGATE: assert property (@(posedge clk) disable iff (rst)
    (a == ~b) |=> (cout == $past(cin) && sum == {WIDTH{!$past(cin)}})); // R4

  AST_ZERO_OPERANDS: assert property (@(posedge clk) disable iff (rst)
    (a == '0 && b == '0) |=> (!cout && sum == WIDTH'($past(cin)))); // R5

  AST_TOP_GENERATE: assert property (@(posedge clk) disable iff (rst)
    (a[WIDTH-1] && b[WIDTH-1]) |=> cout); // R6

endmodule

bind csa_adder_top csa_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .a    (a),
  .b    (b),
  .cin  (cin),
  .sum  (sum),
  .cout (cout)
);

// File: tb/csa_adder_top_tb_top.sv
`timescale 1ns/1ps
module csa_adder_top_tb_top;

  localparam int W4  = 4;
  localparam int W16 = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;

  logic [W4-1:0]  a4 = '0, b4 = '0, s4;
  logic           c4 = 1'b0, co4;
  logic [W16-1:0] a16 = '0, b16 = '0, s16;
  logic           c16 = 1'b0, co16;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  csa_adder_top #(.WIDTH(W4)) dut_i (
    .clk (clk), .rst (rst), .a (a4), .b (b4), .cin (c4),
    .sum (s4), .cout (co4)
  );

  csa_adder_top #(.WIDTH(W16)) dut16_i (
    .clk (clk), .rst (rst), .a (a16), .b (b16), .cin (c16),
    .sum (s16), .cout (co16)
  );

  function automatic logic [W4:0] ref4(input logic [W4-1:0] x, y, input logic c);
    return {1'b0, x} + {1'b0, y} + {{W4{1'b0}}, c};
  endfunction

  function automatic logic [W16:0] ref16(input logic [W16-1:0] x, y, input logic c);
    return {1'b0, x} + {1'b0, y} + {{W16{1'b0}}, c};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run16(input logic [W16-1:0] x, y, input logic c, input string req);
    @(negedge clk);
    a16 = x; b16 = y; c16 = c;
    @(negedge clk);
    chk(req, {15'd0, co16, s16}, {15'd0, ref16(x, y, c)});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset with nonzero operands present
    a4 = 4'hF; b4 = 4'h3; c4 = 1'b1;
    a16 = 16'hFFFF; b16 = 16'h1234; c16 = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 w4", {27'd0, co4, s4}, 32'd0);
    chk("R1 w16", {15'd0, co16, s16}, 32'd0);
    rst = 1'b0;

    // R2/R3: exhaustive width 4, with R4/R5/R6 classes
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        for (int c = 0; c < 2; c++) begin
          @(negedge clk);
          a4 = 4'(x); b4 = 4'(y); c4 = 1'(c);
          @(negedge clk);
          chk("R3 R2 exhaustive", {27'd0, co4, s4}, {27'd0, ref4(4'(x), 4'(y), 1'(c))});
          if (4'(x) == ~4'(y))
            chk("R4 propagate", {27'd0, co4, s4}, c ? 32'h10 : 32'h0F);
          if (x == 0 && y == 0)
            chk("R5 zero operands", {27'd0, co4, s4}, 32'(c));
          if (x >= 8 && y >= 8)
            chk("R6 top generate", {31'd0, co4}, 32'd1);
        end
      end
    end

    // R7: reset in the same cycle as operands
    @(negedge clk);
    rst = 1'b1; a4 = 4'hF; b4 = 4'hF; c4 = 1'b1;
    @(negedge clk);
    chk("R7 reset wins", {27'd0, co4, s4}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 after release", {27'd0, co4, s4}, 32'h1F);

    // R8: width 16 directed corners, propagate chain with cin flip
    run16(16'hFFFF, 16'h0000, 1'b1, "R8 R4 w16 chain cin1");
    run16(16'hAAAA, 16'h5555, 1'b0, "R8 R4 w16 chain cin0");
    run16(16'hAAAA, 16'h5555, 1'b1, "R8 R4 w16 chain cin1");
    run16(16'h8000, 16'h8000, 1'b0, "R8 R6 w16 top generate");
    run16(16'h0000, 16'h0000, 1'b1, "R8 R5 w16 zero");
    run16(16'hFFFF, 16'hFFFF, 1'b1, "R8 w16 all ones");

    // R8: constrained random at width 16
    void'($urandom(32'd20240611));
    for (int n = 0; n < 1500; n++) begin
      logic [W16-1:0] x, y;
      logic c;
      x = 16'($urandom);
      y = 16'($urandom);
      c = 1'($urandom);
      if (n % 8 == 0) y = ~x;
      run16(x, y, c, "R8 w16 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule